// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM. The host issues a single read or write through a valid/ready handshake. The controller then turns that request into a timed sequence of active-low chip-select, output-enable and write-enable strobes. It drives the memory address and the write word, and registers the word the memory returns on a read.

Each interval of the memory cycle is set at run time by a configuration input, counted in clock cycles. These intervals are address setup, write pulse width, data setup, data hold, address hold, and access time from address and from chip select. The controller holds off the next request until the hold interval of the current cycle is over. This lets one configuration cover memories of different speed grades and different clock rates. The configuration inputs are expected to stay constant while a cycle is in flight.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and after reset, with no request accepted, `req_ready` is 1, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the whole cycle ends. It returns to 1 exactly S+X+H cycles after acceptance, where S, X and H are the lengths of the three phases defined below.
- R3: A write first spends S = max(cfg_addr_setup,1) cycles in a setup phase. In this phase `mem_addr` carries the request address and `mem_dq_out` carries the write word with `mem_dq_oe`=1, and all three strobes are 1.
- R4: The write pulse then lasts X = max(cfg_wr_pulse, cfg_data_setup, 1) cycles. During the pulse `mem_cs_n`=0 and `mem_we_n`=0, while `mem_oe_n`=1. Address and data do not change.
- R5: After a write pulse, all strobes are 1 for H = max(cfg_data_hold, cfg_addr_hold, 1) cycles. During this time the address and the write word are still driven with `mem_dq_oe`=1.
- R6: A read spends S cycles in setup with the address driven and all strobes at 1. It then holds `mem_cs_n`=0 and `mem_oe_n`=0, with `mem_we_n`=1, for X = max(cfg_acc_addr, cfg_acc_cs, 1) cycles.
- R7: On a read, `rsp_rdata` takes the value of `mem_dq_in` present in the last cycle of the access phase. `rsp_valid` is 1 for exactly the following cycle. Address hold then lasts H = max(cfg_addr_hold,1) cycles, with strobes at 1 and the address unchanged.
- R8: `mem_dq_oe` is 0 whenever `mem_oe_n` is 0, and is 0 for the whole of every read.
- R9: A configuration count of zero behaves as a count of one, so a cycle with all counts zero takes three cycles from acceptance to ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr_setup | input | CNT_W | Address setup count before strobes |
| cfg_wr_pulse | input | CNT_W | Minimum write-enable low count |
| cfg_data_setup | input | CNT_W | Data setup count before end of write |
| cfg_data_hold | input | CNT_W | Data hold count after end of write |
| cfg_addr_hold | input | CNT_W | Address hold count after strobe release |
| cfg_acc_addr | input | CNT_W | Access count measured from address |
| cfg_acc_cs | input | CNT_W | Access count measured from chip select |
| req_valid | input | 1 | Host request valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write word |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Captured read word |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |
| mem_dq_in | input | DATA_W | Data returned from the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The bench sweeps a grid of interval settings, including all-zero counts, and runs a write followed by a read-back at each point. It compares every cycle of the strobe, address and data trace against phase boundaries computed from the maxima in the requirements. This grid separates a phase that honours only one of its two governing counts from one that honours their maximum. It also catches a zero count that is not raised to one. The behavioural memory returns a poison word until the final access cycle, so a capture made one cycle early shows up as wrong data. A read-back that misses the last written word reveals a write pulse that was cut short.

// File: rtl/sram_strobe_pkg.sv
// Shared types for the asynchronous SRAM strobe controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sram_strobe_pkg;

    // Phases of one memory cycle; IDLE is the only phase that accepts work.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WSETUP  = 3'd1,
        PH_WPULSE  = 3'd2,
        PH_WHOLD   = 3'd3,
        PH_RSETUP  = 3'd4,
        PH_RACCESS = 3'd5,
        PH_RHOLD   = 3'd6
    } phase_e;

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one phase. A load with length L makes done
// assert in the L-th cycle after the load edge.
// Assumes: load_val is never zero (the sequencer clamps it).
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Count remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val - ONE;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_cycle_seq.sv
// Phase sequencer: walks setup, strobe and hold phases of a read or a
// write, each phase length derived from the configuration counts.
// Assumes: configuration is static while a cycle is in flight.
module sram_cycle_seq
    import sram_strobe_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_addr_setup,
    input  logic [CNT_W-1:0] cfg_wr_pulse,
    input  logic [CNT_W-1:0] cfg_data_setup,
    input  logic [CNT_W-1:0] cfg_data_hold,
    input  logic [CNT_W-1:0] cfg_addr_hold,
    input  logic [CNT_W-1:0] cfg_acc_addr,
    input  logic [CNT_W-1:0] cfg_acc_cs,
    input  logic             req_valid,
    input  logic             req_write,
    output phase_e           phase_q,
    output phase_e           phase_d,
    output logic             capture,
    output logic             ready
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    function automatic logic [CNT_W-1:0] larger(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] a);
        return (a == '0) ? ONE : a;
    endfunction

    logic [CNT_W-1:0] len_setup, len_wpulse, len_whold, len_racc, len_rhold;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;

    // Derive every phase length from the configuration counts.
    always_comb begin
        len_setup  = at_least_one(cfg_addr_setup);
        len_wpulse = at_least_one(larger(cfg_wr_pulse, cfg_data_setup));
        len_whold  = at_least_one(larger(cfg_data_hold, cfg_addr_hold));
        len_racc   = at_least_one(larger(cfg_acc_addr, cfg_acc_cs));
        len_rhold  = at_least_one(cfg_addr_hold);
    end

    // Choose the next phase and the length to load into the timer.
    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = ONE;
        unique case (phase_q)
            PH_IDLE: if (req_valid) begin
                phase_d  = req_write ? PH_WSETUP : PH_RSETUP;
                tmr_load = 1'b1;
                tmr_val  = len_setup;
            end
            PH_WSETUP: if (tmr_done) begin
                phase_d  = PH_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = len_wpulse;
            end
            PH_WPULSE: if (tmr_done) begin
                phase_d  = PH_WHOLD;
                tmr_load = 1'b1;
                tmr_val  = len_whold;
            end
            PH_RSETUP: if (tmr_done) begin
                phase_d  = PH_RACCESS;
                tmr_load = 1'b1;
                tmr_val  = len_racc;
            end
            PH_RACCESS: if (tmr_done) begin
                phase_d  = PH_RHOLD;
                tmr_load = 1'b1;
                tmr_val  = len_rhold;
            end
            PH_WHOLD, PH_RHOLD: if (tmr_done) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign ready   = (phase_q == PH_IDLE);
    assign capture = (phase_q == PH_RACCESS) && tmr_done;

    AST_CAPTURE_ENDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (phase_q == PH_RHOLD)); // R7

    AST_PULSE_FOLLOWS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WPULSE) && !$past(phase_q == PH_WPULSE) |-> $past(phase_q == PH_WSETUP)); // R3

endmodule

// File: rtl/sram_pin_drv.sv
// Pin driver: registers the strobes from the next phase so they change
// cleanly on clock edges, holds address and write word for the whole
// cycle, and captures read data at the end of the access phase.
// Assumes: phase_d comes from the sequencer in the same clock domain.
module sram_pin_drv
    import sram_strobe_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_d,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Latch address and write word when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Register strobes and data-driver enable from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= !((phase_d == PH_WPULSE) || (phase_d == PH_RACCESS));
            mem_we_n  <= !(phase_d == PH_WPULSE);
            mem_oe_n  <= !(phase_d == PH_RACCESS);
            mem_dq_oe <= (phase_d == PH_WSETUP) || (phase_d == PH_WPULSE) ||
                         (phase_d == PH_WHOLD);
        end
    end

    // Capture read data at the close of the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= mem_dq_in;
        end
    end

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R8

    AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n)); // R6

    AST_WE_RISE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)); // R5

    AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n) && mem_oe_n); // R7

endmodule

// File: rtl/sram_strobe_ctrl.sv
// Top level: host valid/ready port in, timed asynchronous SRAM strobes
// out. One request is in flight at a time.
// Assumes: configuration inputs are stable while req_ready is low.
module sram_strobe_ctrl
    import sram_strobe_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_addr_setup,
    input  logic [CNT_W-1:0]  cfg_wr_pulse,
    input  logic [CNT_W-1:0]  cfg_data_setup,
    input  logic [CNT_W-1:0]  cfg_data_hold,
    input  logic [CNT_W-1:0]  cfg_addr_hold,
    input  logic [CNT_W-1:0]  cfg_acc_addr,
    input  logic [CNT_W-1:0]  cfg_acc_cs,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    phase_e phase_q, phase_d;
    logic   capture;
    logic   accept;

    assign accept = req_valid && req_ready;

    sram_cycle_seq #(.CNT_W(CNT_W)) seq_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_addr_setup (cfg_addr_setup),
        .cfg_wr_pulse   (cfg_wr_pulse),
        .cfg_data_setup (cfg_data_setup),
        .cfg_data_hold  (cfg_data_hold),
        .cfg_addr_hold  (cfg_addr_hold),
        .cfg_acc_addr   (cfg_acc_addr),
        .cfg_acc_cs     (cfg_acc_cs),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .phase_q        (phase_q),
        .phase_d        (phase_d),
        .capture        (capture),
        .ready          (req_ready)
    );

    sram_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) drv_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_d    (phase_d),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    AST_BUSY_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(mem_addr)); // R2

    AST_IDLE_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe); // R1

endmodule

// File: tb/sram_strobe_ctrl_tb_top.sv
// Bench: sweeps interval settings, runs write then read-back at each,
// and checks every cycle of the pin trace against computed phase bounds.
module sram_strobe_ctrl_tb_top;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] c_as = '0, c_wp = '0, c_ds = '0, c_dh = '0, c_ah = '0, c_aa = '0, c_ac = '0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, mem_dq_oe, mem_cs_n, mem_oe_n, mem_we_n;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sram_strobe_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr_setup(c_as), .cfg_wr_pulse(c_wp), .cfg_data_setup(c_ds),
        .cfg_data_hold(c_dh), .cfg_addr_hold(c_ah), .cfg_acc_addr(c_aa), .cfg_acc_cs(c_ac),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // Behavioural memory: stores on write strobes, returns poison until
    // the access time the bench expects has elapsed.
    logic [DW-1:0] cells [16];
    logic [DW-1:0] shadow [16];
    int oe_run = 0;
    int need_acc = 1;

    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n) cells[mem_addr] <= mem_dq_out;
        oe_run <= mem_oe_n ? 0 : oe_run + 1;
    end

    always_comb begin
        if (!mem_cs_n && !mem_oe_n && (oe_run >= need_acc - 1))
            mem_dq_in = cells[mem_addr];
        else
            mem_dq_in = 8'hEE;
    end

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic int cl(input int a);
        return (a == 0) ? 1 : a;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one host operation and compare every cycle of the trace.
    task automatic run_op(input bit wr, input int a, input int d);
        int s, x, h, total, rsp_seen, rdata_got;
        int e_set, e_str, e_hold, e_rdy, e_con;
        s = cl(int'(c_as));
        if (wr) begin
            x = cl(mx(int'(c_wp), int'(c_ds)));
            h = cl(mx(int'(c_dh), int'(c_ah)));
        end else begin
            x = cl(mx(int'(c_aa), int'(c_ac)));
            h = cl(int'(c_ah));
        end
        need_acc = x;
        total = s + x + h;
        e_set = 0; e_str = 0; e_hold = 0; e_rdy = 0; e_con = 0;
        rsp_seen = 0; rdata_got = -1;
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~req_addr;
        req_wdata = ~req_wdata;
        for (int j = 0; j <= total; j++) begin
            bit in_str;
            in_str = (j >= s) && (j < s + x);
            if (req_ready !== (j == total)) e_rdy++;
            if (!mem_oe_n && mem_dq_oe) e_con++;
            if (j < total && mem_addr !== AW'(a)) begin
                if (j < s) e_set++; else if (in_str) e_str++; else e_hold++;
            end
            if (j < s) begin
                if (!(mem_cs_n && mem_we_n && mem_oe_n) || mem_dq_oe !== wr) e_set++;
                if (wr && mem_dq_out !== DW'(d)) e_set++;
            end else if (in_str) begin
                if (mem_cs_n !== 1'b0 || mem_we_n !== !wr || mem_oe_n !== wr || mem_dq_oe !== wr) e_str++;
                if (wr && mem_dq_out !== DW'(d)) e_str++;
            end else if (j < total) begin
                if (!(mem_cs_n && mem_we_n && mem_oe_n) || mem_dq_oe !== wr) e_hold++;
                if (wr && mem_dq_out !== DW'(d)) e_hold++;
            end
            if (rsp_valid) begin
                rsp_seen++;
                if (j != s + x) e_hold++;
                rdata_got = int'(rsp_rdata);
            end
            if (j < total) @(negedge clk);
        end
        if (wr) begin
            check(e_set == 0, "R3 write setup phase", e_set, 0);
            check(e_str == 0, "R4 write pulse phase", e_str, 0);
            check(e_hold == 0, "R5 write hold phase", e_hold, 0);
            check(rsp_seen == 0, "R7 no response on write", rsp_seen, 0);
            shadow[a] = DW'(d);
        end else begin
            check(e_set == 0 && e_str == 0, "R6 read setup and access", e_set + e_str, 0);
            check(e_hold == 0 && rsp_seen == 1, "R7 read hold and single response", rsp_seen, 1);
            check(rdata_got == int'(shadow[a]), "R7 read data", rdata_got, int'(shadow[a]));
        end
        check(e_rdy == 0, "R2 ready timing", e_rdy, 0);
        check(e_con == 0, "R8 no driver contention", e_con, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
              "R1 reset state", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
              "R1 idle after reset", int'(req_ready), 1);

        // R9: all counts zero, each phase one cycle.
        run_op(1'b1, 5, 8'h3C);
        run_op(1'b0, 5, 0);
        run_op(1'b1, 5, 8'hC3);
        run_op(1'b0, 5, 0);

        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 4; p++) begin
                for (int a = 0; a < 4; a++) begin
                    int idx;
                    idx = s * 16 + p * 4 + a;
                    c_as = CW'(s);
                    c_wp = CW'(p);
                    c_ds = CW'((p + s + 1) % 4);
                    c_dh = CW'(a % 3);
                    c_ah = CW'((a + s) % 3);
                    c_aa = CW'(a);
                    c_ac = CW'((3 - a + p) % 4);
                    run_op(1'b1, idx % 16, (idx * 37 + 11) % 256);
                    run_op(1'b0, idx % 16, 0);
                end
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule